// File: doc/BRIEF.md
# Caption Line Byte Acquisition

This block picks the two caption characters out of one video line. The incoming line has already been sliced into a serial bit stream. The block receives a field-start strobe that carries the identity of the new field. It also receives a line strobe, and a data bit that is qualified by a bit strobe. From these it counts lines within each field and decides whether the current line lies in the acquisition window. If it does, the block shifts in sixteen bits and checks odd parity on each 8-bit character. It then presents both characters with a per-character error flag and pulses a ready output. The ready pulse is accompanied by the identity of the field the pair came from.

Three control inputs shape acquisition:
- A field selector picks which field is decoded in the normal single-line mode.
- A window control widens the search to a band of lines around the caption line in both fields. In this mode the first complete pair found in a field wins.
- An inhibit input blocks capture completely.

Top module: `cap_acq`

## Requirements
- R1: After reset, `first_o` and `second_o` are 0x00, `rdy_o` is 0 and `src_field_o` is 0.
- R2: A field strobe sets the line number to 0, and each line strobe after it adds one, so line N is the span after the N-th line strobe of the field. The field strobe also samples `vs_field_i` as the field identity: 0 is the first field and 1 is the second.
- R3: With `wide_win_i` = 0, bits are taken only on line 21 and only in the field whose identity equals `field_sel_i`.
- R4: With `wide_win_i` = 1, bits are taken on lines 19 to 23 of either field. The first line in a field that delivers 16 bits is accepted. Later lines of that field are ignored until the next field strobe.
- R5: Bits arrive least significant first, and the first 8 bits form the first character. Bits 6:0 of each output hold received bits 0 to 6. Bit 7 is a parity-error flag: it is 1 when the 8 received bits hold an even number of ones, and 0 when they hold an odd number.
- R6: Consider the clock edge that takes the 16th bit. At that edge `first_o`, `second_o` and `src_field_o` update, and `rdy_o` goes high for exactly one cycle. At all other times the outputs hold.
- R7: While `inhibit_i` = 1, no bit is taken and no ready pulse occurs.
- R8: A line strobe discards a partly received pair. A line with fewer than 16 bits produces nothing, and its bits do not carry into the next line.
- R9: At most one pair is accepted per field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vs_stb_i | input | 1 | Field start strobe, one cycle |
| vs_field_i | input | 1 | Identity of the field that begins (0 first, 1 second) |
| hs_stb_i | input | 1 | Line strobe, one cycle |
| bit_vld_i | input | 1 | Sliced bit strobe |
| bit_dat_i | input | 1 | Sliced bit value |
| field_sel_i | input | 1 | Field decoded in single-line mode |
| wide_win_i | input | 1 | 1 selects the lines 19-23 band in both fields |
| inhibit_i | input | 1 | 1 blocks acquisition |
| first_o | output | 8 | First character, bit 7 parity-error flag |
| second_o | output | 8 | Second character, bit 7 parity-error flag |
| rdy_o | output | 1 | One-cycle pulse when a new pair is presented |
| src_field_o | output | 1 | Field identity of the presented pair |

## Verification
Some faults in internal state show at the ports within one line, either as a missing ready pulse or as a pulse on the wrong line:
- a line counter that is off by one;
- a field identity that is latched wrongly;
- a window decode that is wrong.

A shift register or bit counter that slips shows on the very next pair, as rotated data bits or wrong parity flags. A per-field acceptance flag that fails to clear or set shows within one field, as a lost pair or a second pulse in the same field.

// File: rtl/cap_acq_pkg.sv
package cap_acq_pkg;
   typedef enum logic {
      FLD_FIRST  = 1'b0,
      FLD_SECOND = 1'b1
   } fld_e;

   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_e;
endpackage

// File: rtl/cap_line_ctr.sv
module cap_line_ctr
   import cap_acq_pkg::*;
#(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs_stb,
   input  logic              vs_field,
   input  logic              hs_stb,
   output logic [LINE_W-1:0] line_q,
   output fld_e              field_q
);
   localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q  <= '0;
         field_q <= FLD_FIRST;
      end else if (vs_stb) begin
         line_q  <= '0;
         field_q <= fld_e'(vs_field);
      end else if (hs_stb && line_q != LINE_MAX) begin
         line_q  <= line_q + 1'b1;
      end
   end
endmodule

// File: rtl/cap_win_sel.sv
module cap_win_sel
   import cap_acq_pkg::*;
#(
   parameter int LINE_W      = 10,
   parameter int TARGET_LINE = 21,
   parameter int WIN_LO      = 19,
   parameter int WIN_HI      = 23
) (
   input  logic [LINE_W-1:0] line_i,
   input  fld_e              field_i,
   input  logic              field_sel_i,
   input  logic              wide_i,
   output logic              hit_o
);
   localparam logic [LINE_W-1:0] L_TGT = LINE_W'(TARGET_LINE);
   localparam logic [LINE_W-1:0] L_LO  = LINE_W'(WIN_LO);
   localparam logic [LINE_W-1:0] L_HI  = LINE_W'(WIN_HI);

   logic narrow_hit, band_hit;

   always_comb begin
      narrow_hit = (line_i == L_TGT) && (field_i == fld_e'(field_sel_i));
      band_hit   = (line_i >= L_LO) && (line_i <= L_HI);
      hit_o      = wide_i ? band_hit : narrow_hit;
   end
endmodule

// File: rtl/cap_shift.sv
module cap_shift #(
   parameter int TOT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             din,
   output logic [TOT_W-1:0] word_nxt,
   output logic             last
);
   localparam int CNT_W = $clog2(TOT_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TOT_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOT_W - 1);

   logic [TOT_W-1:0] sreg_q;
   logic [CNT_W-1:0] cnt_q;

   assign word_nxt = {din, sreg_q[TOT_W-1:1]};
   assign last     = en && (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         sreg_q <= '0;
         cnt_q  <= '0;
      end else if (en && cnt_q != CNT_FULL) begin
         sreg_q <= word_nxt;
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cap_byte_fmt.sv
module cap_byte_fmt
   import cap_acq_pkg::*;
#(
   parameter int   CHAR_W = 8,
   parameter par_e PAR    = PAR_ODD
) (
   input  logic [CHAR_W-1:0] raw_i,
   output logic [CHAR_W-1:0] fmt_o
);
   logic err;

   generate
      if (PAR == PAR_ODD) begin : g_odd
         assign err = ~(^raw_i);
      end else begin : g_even
         assign err = ^raw_i;
      end
   endgenerate

   assign fmt_o = {err, raw_i[CHAR_W-2:0]};
endmodule

// File: rtl/cap_acq.sv
module cap_acq
   import cap_acq_pkg::*;
#(
   parameter int   CHAR_W      = 8,
   parameter int   LINE_W      = 10,
   parameter int   TARGET_LINE = 21,
   parameter int   WIN_LO      = 19,
   parameter int   WIN_HI      = 23,
   parameter par_e PAR         = PAR_ODD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs_stb_i,
   input  logic              vs_field_i,
   input  logic              hs_stb_i,
   input  logic              bit_vld_i,
   input  logic              bit_dat_i,
   input  logic              field_sel_i,
   input  logic              wide_win_i,
   input  logic              inhibit_i,
   output logic [CHAR_W-1:0] first_o,
   output logic [CHAR_W-1:0] second_o,
   output logic              rdy_o,
   output logic              src_field_o
);
   localparam int NCHR  = 2;
   localparam int TOT_W = NCHR * CHAR_W;

   generate
      if (CHAR_W < 2) begin : g_bad_char
         $error("cap_acq: CHAR_W must be at least 2");
      end
      if (!(WIN_LO <= TARGET_LINE && TARGET_LINE <= WIN_HI)) begin : g_bad_win
         $error("cap_acq: target line must sit inside the wide band");
      end
      if (WIN_HI >= (1 << LINE_W)) begin : g_bad_line
         $error("cap_acq: LINE_W too small for the window");
      end
   endgenerate

   logic [LINE_W-1:0]             line_q;
   fld_e                          field_q;
   logic                          hit, open_w, clr_w, en_w, last_w, done_q;
   logic [TOT_W-1:0]              word_nxt;
   logic [NCHR-1:0][CHAR_W-1:0]   fmt_w;

   cap_line_ctr #(.LINE_W(LINE_W)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .vs_stb  (vs_stb_i),
      .vs_field(vs_field_i),
      .hs_stb  (hs_stb_i),
      .line_q  (line_q),
      .field_q (field_q)
   );

   cap_win_sel #(
      .LINE_W(LINE_W), .TARGET_LINE(TARGET_LINE),
      .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
   ) u_win (
      .line_i     (line_q),
      .field_i    (field_q),
      .field_sel_i(field_sel_i),
      .wide_i     (wide_win_i),
      .hit_o      (hit)
   );

   assign open_w = hit && !inhibit_i && !done_q;
   assign clr_w  = hs_stb_i || vs_stb_i;
   assign en_w   = bit_vld_i && open_w && !clr_w;

   cap_shift #(.TOT_W(TOT_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_w),
      .en      (en_w),
      .din     (bit_dat_i),
      .word_nxt(word_nxt),
      .last    (last_w)
   );

   generate
      for (genvar k = 0; k < NCHR; k++) begin : g_fmt
         cap_byte_fmt #(.CHAR_W(CHAR_W), .PAR(PAR)) u_fmt (
            .raw_i(word_nxt[k*CHAR_W +: CHAR_W]),
            .fmt_o(fmt_w[k])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_o     <= '0;
         second_o    <= '0;
         rdy_o       <= 1'b0;
         src_field_o <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         rdy_o <= last_w;
         if (last_w) begin
            first_o     <= fmt_w[0];
            second_o    <= fmt_w[1];
            src_field_o <= field_q;
         end
         if (vs_stb_i)    done_q <= 1'b0;
         else if (last_w) done_q <= 1'b1;
      end
   end
endmodule

// File: rtl/cap_acq_chk.sv
module cap_acq_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vs_stb_i,
   input logic              field_sel_i,
   input logic              wide_win_i,
   input logic              inhibit_i,
   input logic [CHAR_W-1:0] first_o,
   input logic [CHAR_W-1:0] second_o,
   input logic              rdy_o,
   input logic              src_field_o
);
   logic [1:0] n_acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            n_acc_q <= '0;
      else if (vs_stb_i)     n_acc_q <= '0;
      else if (rdy_o && n_acc_q != 2'd3) n_acc_q <= n_acc_q + 1'b1;
   end

   p_rdy_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |=> !rdy_o);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_o |-> ($stable(first_o) && $stable(second_o) && $stable(src_field_o)));

   p_no_take_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |-> !$past(inhibit_i));

   p_field_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_o && !$past(wide_win_i)) |-> (src_field_o == $past(field_sel_i)));

   p_one_per_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |-> (n_acc_q == 2'd0));
endmodule

bind cap_acq cap_acq_chk #(.CHAR_W(CHAR_W)) u_cap_acq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vs_stb_i   (vs_stb_i),
   .field_sel_i(field_sel_i),
   .wide_win_i (wide_win_i),
   .inhibit_i  (inhibit_i),
   .first_o    (first_o),
   .second_o   (second_o),
   .rdy_o      (rdy_o),
   .src_field_o(src_field_o)
);

// File: tb/tb_cap_acq.sv
`timescale 1ns/1ps
module tb_cap_acq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vs_stb = 0, vs_field = 0, hs_stb = 0, bit_vld = 0, bit_dat = 0;
   logic field_sel = 0, wide_win = 0, inhibit = 0;
   logic [7:0] first_o, second_o;
   logic rdy_o, src_field_o;

   int n_chk = 0, n_bad = 0, cur_line = 0, rdy_seen = 0, rdy_exp = 0;
   logic [7:0] e_first = 8'h00, e_second = 8'h00;
   logic e_src = 1'b0;
   bit finished = 0;

   always #4 clk = ~clk;

   cap_acq dut (
      .clk(clk), .rst_n(rst_n), .vs_stb_i(vs_stb), .vs_field_i(vs_field),
      .hs_stb_i(hs_stb), .bit_vld_i(bit_vld), .bit_dat_i(bit_dat),
      .field_sel_i(field_sel), .wide_win_i(wide_win), .inhibit_i(inhibit),
      .first_o(first_o), .second_o(second_o), .rdy_o(rdy_o),
      .src_field_o(src_field_o)
   );

   always @(negedge clk) if (rst_n && rdy_o) rdy_seen++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mk(input logic [6:0] d);
      return {~(^d), d};
   endfunction

   function automatic logic [7:0] fmt(input logic [7:0] raw);
      return {~(^raw), raw[6:0]};
   endfunction

   task automatic start_field(input logic f);
      @(negedge clk); vs_stb = 1; vs_field = f;
      @(negedge clk); vs_stb = 0;
      cur_line = 0;
   endtask

   task automatic goto_line(input int n);
      while (cur_line < n) begin
         @(negedge clk); hs_stb = 1;
         @(negedge clk); hs_stb = 0;
         cur_line++;
      end
   endtask

   task automatic send_pair(input logic [7:0] r1, input logic [7:0] r2,
                            input int nbits, output logic got);
      logic [15:0] w;
      w = {r2, r1};
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk); bit_vld = 1; bit_dat = w[i];
         @(negedge clk); bit_vld = 0;
      end
      got = rdy_o;
   endtask

   task automatic check_outs(input string tag);
      chk(first_o == e_first, {tag, " first"}, first_o, e_first);
      chk(second_o == e_second, {tag, " second"}, second_o, e_second);
      chk(src_field_o == e_src, {tag, " src_field"}, src_field_o, e_src);
   endtask

   task automatic expect_take(input logic got, input logic [7:0] r1, input logic [7:0] r2,
                              input logic f, input string tag);
      chk(got == 1'b1, {tag, " R6 rdy after 16th bit"}, got, 1);
      e_first = fmt(r1); e_second = fmt(r2); e_src = f; rdy_exp++;
      check_outs(tag);
      @(negedge clk);
      chk(rdy_o == 1'b0, {tag, " R6 rdy one cycle"}, rdy_o, 0);
   endtask

   task automatic t_reset;
      chk(first_o == 8'h00, "R1 first", first_o, 0);
      chk(second_o == 8'h00, "R1 second", second_o, 0);
      chk(rdy_o == 1'b0, "R1 rdy", rdy_o, 0);
      chk(src_field_o == 1'b0, "R1 src", src_field_o, 0);
   endtask

   task automatic t_narrow_first;
      logic g;
      field_sel = 0; wide_win = 0;
      start_field(0); goto_line(21);
      send_pair(mk(7'h41), mk(7'h42), 16, g);
      expect_take(g, mk(7'h41), mk(7'h42), 0, "R2 R3 R5 narrow first field");
   endtask

   task automatic t_parity;
      logic g;
      start_field(0); goto_line(21);
      send_pair(mk(7'h20), mk(7'h15) ^ 8'h80, 16, g);
      expect_take(g, mk(7'h20), mk(7'h15) ^ 8'h80, 0, "R5 parity");
      chk(second_o == 8'h95, "R5 error flag bit7", second_o, 8'h95);
      chk(first_o == 8'h20, "R5 clean flag bit7", first_o, 8'h20);
   endtask

   task automatic t_field_sel;
      logic g;
      field_sel = 0; wide_win = 0;
      start_field(1); goto_line(21);
      send_pair(mk(7'h33), mk(7'h34), 16, g);
      chk(g == 1'b0, "R3 other field ignored", g, 0);
      check_outs("R3 other field hold");
      field_sel = 1;
      start_field(1); goto_line(21);
      send_pair(mk(7'h51), mk(7'h52), 16, g);
      expect_take(g, mk(7'h51), mk(7'h52), 1, "R3 second field");
      field_sel = 0;
   endtask

   task automatic t_wrong_line;
      logic g;
      start_field(0); goto_line(20);
      send_pair(mk(7'h61), mk(7'h62), 16, g);
      chk(g == 1'b0, "R2 R3 line 20 ignored", g, 0);
      goto_line(22);
      send_pair(mk(7'h63), mk(7'h64), 16, g);
      chk(g == 1'b0, "R2 R3 line 22 ignored", g, 0);
      check_outs("R3 wrong line hold");
   endtask

   task automatic t_wide;
      logic g;
      wide_win = 1; field_sel = 0;
      start_field(1); goto_line(19);
      send_pair(mk(7'h11), mk(7'h12), 16, g);
      expect_take(g, mk(7'h11), mk(7'h12), 1, "R4 wide line 19 other field");
      goto_line(22);
      send_pair(mk(7'h13), mk(7'h14), 16, g);
      chk(g == 1'b0, "R4 R9 later line ignored", g, 0);
      check_outs("R9 later line hold");
      start_field(0); goto_line(23);
      send_pair(mk(7'h21), mk(7'h22), 16, g);
      expect_take(g, mk(7'h21), mk(7'h22), 0, "R4 wide line 23");
      start_field(0); goto_line(18);
      send_pair(mk(7'h23), mk(7'h24), 16, g);
      chk(g == 1'b0, "R4 line 18 outside band", g, 0);
      goto_line(24);
      send_pair(mk(7'h25), mk(7'h26), 16, g);
      chk(g == 1'b0, "R4 line 24 outside band", g, 0);
      check_outs("R4 outside band hold");
   endtask

   task automatic t_partial;
      logic g;
      wide_win = 1;
      start_field(0); goto_line(19);
      send_pair(8'hFF, 8'hFF, 10, g);
      chk(g == 1'b0, "R8 short line no pair", g, 0);
      goto_line(20);
      send_pair(mk(7'h0A), mk(7'h70), 16, g);
      expect_take(g, mk(7'h0A), mk(7'h70), 0, "R8 no carry-over");
      wide_win = 0;
      start_field(0); goto_line(21);
      send_pair(mk(7'h01), mk(7'h02), 15, g);
      goto_line(22);
      chk(rdy_o == 1'b0, "R8 fifteen bits no pair", rdy_o, 0);
      check_outs("R8 short hold");
   endtask

   task automatic t_inhibit;
      logic g;
      wide_win = 0; field_sel = 0; inhibit = 1;
      start_field(0); goto_line(21);
      send_pair(mk(7'h44), mk(7'h45), 16, g);
      chk(g == 1'b0, "R7 inhibit blocks", g, 0);
      check_outs("R7 inhibit hold");
      inhibit = 0;
      start_field(0); goto_line(21);
      send_pair(mk(7'h46), mk(7'h47), 16, g);
      expect_take(g, mk(7'h46), mk(7'h47), 0, "R7 release");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_narrow_first;
      t_parity;
      t_field_sel;
      t_wrong_line;
      t_wide;
      t_partial;
      t_inhibit;
      repeat (4) @(negedge clk);
      chk(rdy_seen == rdy_exp, "R9 total ready pulses", rdy_seen, rdy_exp);
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule